// File: doc/BRIEF.md
# Inclusive Two-Level Line Coherency Controller

This block keeps the coherency state of a single cache line held by one processor in a first-level (L1) and second-level (L2) cache. Both levels are write-back and inclusive: L1 can hold the line only while L2 does. Each cycle the block may receive processor reads and writes and reads and writes from a cacheless external agent such as a DMA engine. It updates the state of both levels and raises one-cycle action strobes that tell the data path which transfers to make: fill L2 from memory, fill L1 from L2, write processor data into L2, write L1 back to L2 and memory, or write L2 back to memory.

The two states are coupled so that memory is never stale without the block knowing it. L2 is never Shared. L1 takes Shared whenever L2 is Exclusive, so the first processor write to L1 is also written through to L2 and marks L2 Modified. An external write to a modified line takes two cycles. The write-back strobe comes first, and both levels become Invalid one cycle later.

Top module: `mesi_line_ctl`

## Requirements
- R1: While reset is active and after it is released, both states read Invalid and every strobe is low. The state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: Requests are sampled on a rising clock edge. The resulting states and strobes appear right after that same edge, and every strobe lasts exactly one cycle.
- R3: A processor read that misses both levels raises fill_l2_mem and fill_l1_l2 together and leaves L2 Exclusive and L1 Shared.
- R4: A processor read that misses L1 but hits L2 raises only fill_l1_l2. L1 becomes Exclusive if L2 is Modified and Shared if L2 is Exclusive, and L2 is unchanged. A processor read that hits L1 changes nothing and raises no strobe.
- R5: A processor write to L1 in Shared raises wr_l2 and leaves L1 Exclusive and L2 Modified.
- R6: A processor write to L1 in Exclusive makes L1 Modified with no strobe. A write to L1 in Modified leaves both levels Modified with no strobe.
- R7: A processor write that misses L1 fills what is missing (fill_l2_mem only if L2 also misses, always fill_l1_l2), raises wr_l2, and ends with L1 Exclusive and L2 Modified.
- R8: An external read while L1 is Modified raises wb_l1 and leaves L1 Shared and L2 Exclusive.
- R9: An external read while L2 is Modified and L1 is not raises wb_l2, leaves L2 Exclusive, and sets L1 to Shared if it held the line and Invalid otherwise. An external read of an unmodified line changes nothing.
- R10: An external write to an unmodified or absent line makes both levels Invalid after one edge, with no strobe.
- R11: An external write to a modified line raises exactly one write-back strobe for one cycle: wb_l1 if L1 is Modified, otherwise wb_l2. States stay unchanged during that cycle. Both levels become Invalid on the next edge, and any request sampled on that edge is ignored.
- R12: When several requests arrive together, only one is served, in this order: external write, external read, processor write, processor read.
- R13: A low l1_present makes L1 count as Invalid. A low l2_present makes both levels count as Invalid. The stored state takes that value on the next edge.
- R14: The state pair is always legal. L2 is never Shared, L1 is never Modified unless L2 is Modified, and L1 is Invalid whenever L2 is Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_rd | input | 1 | Processor read request |
| pr_wr | input | 1 | Processor write request |
| ext_rd | input | 1 | External agent read request |
| ext_wr | input | 1 | External agent write request |
| l1_present | input | 1 | L1 still holds this line |
| l2_present | input | 1 | L2 still holds this line |
| l1_state | output | 2 | Current L1 state |
| l2_state | output | 2 | Current L2 state |
| fill_l2_mem | output | 1 | Strobe: load L2 from memory |
| fill_l1_l2 | output | 1 | Strobe: load L1 from L2 |
| wr_l2 | output | 1 | Strobe: write processor data into L2 |
| wb_l1 | output | 1 | Strobe: copy L1 to L2 and memory |
| wb_l2 | output | 1 | Strobe: copy L2 to memory |

## Verification
Every state change and strobe is due in the cycle after the edge that sampled the request. The one exception is the invalidation after a modified external write, which is due one cycle later still. The bench's reference model advances on the same edge as the design, and the comparison runs 1 ns after each rising edge, so the result of each request is checked in the cycle it is due. Because the model is compared on every cycle, a strobe that lasts too long or a state that changes early is caught as well. Directed sequences visit each transition, and a long mixed run combines simultaneous requests with dropped presence flags.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  // request order doubles as priority: highest index wins
  localparam int unsigned REQ_PR_RD  = 0;
  localparam int unsigned REQ_PR_WR  = 1;
  localparam int unsigned REQ_EXT_RD = 2;
  localparam int unsigned REQ_EXT_WR = 3;
  localparam int unsigned NUM_REQ    = 4;

  typedef struct packed {
    logic fill_l2_mem;
    logic fill_l1_l2;
    logic wr_l2;
    logic wb_l1;
    logic wb_l2;
  } act_t;
endpackage

// File: rtl/mesi_req_arb.sv
module mesi_req_arb #(
  parameter int unsigned NREQ = 4
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt
);
  // fixed priority, highest index first
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_line_pkg::*;
#(
  parameter int unsigned NREQ = NUM_REQ
) (
  input  logic [NREQ-1:0] gnt,
  input  logic            l1_present,
  input  logic            l2_present,
  input  mesi_t           l1_q,
  input  mesi_t           l2_q,
  input  logic            pend_q,
  output mesi_t           l1_d,
  output mesi_t           l2_d,
  output act_t            act_d,
  output logic            pend_d,
  output logic            st_en
);
  mesi_t eff1, eff2;

  always_comb begin
    eff2 = l2_present ? l2_q : ST_I;
    eff1 = (l1_present && l2_present) ? l1_q : ST_I;
  end

  always_comb begin
    l1_d   = eff1;
    l2_d   = eff2;
    act_d  = '0;
    pend_d = 1'b0;
    if (pend_q) begin
      // write-back went out last cycle; now drop both copies
      l1_d = ST_I;
      l2_d = ST_I;
    end else if (gnt[REQ_EXT_WR]) begin
      if (eff1 == ST_M) begin
        act_d.wb_l1 = 1'b1;
        pend_d      = 1'b1;
      end else if (eff2 == ST_M) begin
        act_d.wb_l2 = 1'b1;
        pend_d      = 1'b1;
      end else begin
        l1_d = ST_I;
        l2_d = ST_I;
      end
    end else if (gnt[REQ_EXT_RD]) begin
      if (eff1 == ST_M) begin
        act_d.wb_l1 = 1'b1;
        l1_d        = ST_S;
        l2_d        = ST_E;
      end else if (eff2 == ST_M) begin
        act_d.wb_l2 = 1'b1;
        l2_d        = ST_E;
        l1_d        = (eff1 != ST_I) ? ST_S : ST_I;
      end
    end else if (gnt[REQ_PR_WR]) begin
      unique case (eff1)
        ST_I: begin
          act_d.fill_l2_mem = (eff2 == ST_I);
          act_d.fill_l1_l2  = 1'b1;
          act_d.wr_l2       = 1'b1;
          l1_d              = ST_E;
          l2_d              = ST_M;
        end
        ST_S: begin
          act_d.wr_l2 = 1'b1;
          l1_d        = ST_E;
          l2_d        = ST_M;
        end
        default: l1_d = ST_M;
      endcase
    end else if (gnt[REQ_PR_RD]) begin
      if (eff1 == ST_I) begin
        act_d.fill_l1_l2 = 1'b1;
        if (eff2 == ST_I) begin
          act_d.fill_l2_mem = 1'b1;
          l2_d              = ST_E;
          l1_d              = ST_S;
        end else begin
          l1_d = (eff2 == ST_M) ? ST_E : ST_S;
        end
      end
    end
  end

  assign st_en = pend_q | (|gnt) | (eff1 != l1_q) | (eff2 != l2_q);
endmodule

// File: rtl/mesi_line_regs.sv
module mesi_line_regs
  import mesi_line_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  st_en,
  input  mesi_t l1_d,
  input  mesi_t l2_d,
  input  act_t  act_d,
  input  logic  pend_d,
  output mesi_t l1_q,
  output mesi_t l2_q,
  output act_t  act_q,
  output logic  pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_q <= ST_I;
      l2_q <= ST_I;
    end else if (st_en) begin
      l1_q <= l1_d;
      l2_q <= l2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  // R14
  legal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_q != ST_S) && (l1_q != ST_M || l2_q == ST_M) && (l1_q == ST_I || l2_q != ST_I));

  // R11
  inval_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (l1_q == ST_I && l2_q == ST_I));

  // R11
  pend_has_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> $onehot({act_q.wb_l1, act_q.wb_l2}));

  // R11
  single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_q.wb_l1, act_q.wb_l2}));

  // R4
  l1_fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.fill_l1_l2 |-> (l1_q != ST_I && l2_q != ST_I));

  // R5
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.wr_l2 |-> (l1_q == ST_E && l2_q == ST_M));
endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
  import mesi_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pr_rd,
  input  logic       pr_wr,
  input  logic       ext_rd,
  input  logic       ext_wr,
  input  logic       l1_present,
  input  logic       l2_present,
  output logic [1:0] l1_state,
  output logic [1:0] l2_state,
  output logic       fill_l2_mem,
  output logic       fill_l1_l2,
  output logic       wr_l2,
  output logic       wb_l1,
  output logic       wb_l2
);
  localparam int unsigned NREQ = NUM_REQ;

  logic [NREQ-1:0] req, gnt;
  mesi_t           l1_q, l2_q, l1_d, l2_d;
  act_t            act_d, act_q;
  logic            pend_d, pend_q, st_en;

  always_comb begin
    req             = '0;
    req[REQ_PR_RD]  = pr_rd;
    req[REQ_PR_WR]  = pr_wr;
    req[REQ_EXT_RD] = ext_rd;
    req[REQ_EXT_WR] = ext_wr;
  end

  mesi_req_arb #(.NREQ(NREQ)) u_arb (
    .req (req),
    .gnt (gnt)
  );

  mesi_next_state #(.NREQ(NREQ)) u_next (
    .gnt        (gnt),
    .l1_present (l1_present),
    .l2_present (l2_present),
    .l1_q       (l1_q),
    .l2_q       (l2_q),
    .pend_q     (pend_q),
    .l1_d       (l1_d),
    .l2_d       (l2_d),
    .act_d      (act_d),
    .pend_d     (pend_d),
    .st_en      (st_en)
  );

  mesi_line_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_en  (st_en),
    .l1_d   (l1_d),
    .l2_d   (l2_d),
    .act_d  (act_d),
    .pend_d (pend_d),
    .l1_q   (l1_q),
    .l2_q   (l2_q),
    .act_q  (act_q),
    .pend_q (pend_q)
  );

  assign l1_state    = l1_q;
  assign l2_state    = l2_q;
  assign fill_l2_mem = act_q.fill_l2_mem;
  assign fill_l1_l2  = act_q.fill_l1_l2;
  assign wr_l2       = act_q.wr_l2;
  assign wb_l1       = act_q.wb_l1;
  assign wb_l2       = act_q.wb_l2;
endmodule

// File: tb/mesi_line_ctl_bench.sv
module mesi_line_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pr_rd = 1'b0, pr_wr = 1'b0, ext_rd = 1'b0, ext_wr = 1'b0;
  logic l1_present = 1'b1, l2_present = 1'b1;
  logic [1:0] l1_state, l2_state;
  logic fill_l2_mem, fill_l1_l2, wr_l2, wb_l1, wb_l2;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R2";

  // reference model: 0=I 1=S 2=E 3=M
  int m1 = 0, m2 = 0, mpend = 0;
  bit xf2 = 0, xf1 = 0, xw2 = 0, xb1 = 0, xb2 = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctl u_mesi_line_ctl (
    .clk(clk), .rst_n(rst_n), .pr_rd(pr_rd), .pr_wr(pr_wr),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .l1_present(l1_present),
    .l2_present(l2_present), .l1_state(l1_state), .l2_state(l2_state),
    .fill_l2_mem(fill_l2_mem), .fill_l1_l2(fill_l1_l2), .wr_l2(wr_l2),
    .wb_l1(wb_l1), .wb_l2(wb_l2)
  );

  always @(posedge clk) begin
    int a1, a2;
    if (!rst_n) begin
      m1 = 0; m2 = 0; mpend = 0;
      {xf2, xf1, xw2, xb1, xb2} = '0;
    end else begin
      a2 = l2_present ? m2 : 0;
      a1 = (l1_present && l2_present) ? m1 : 0;
      {xf2, xf1, xw2, xb1, xb2} = '0;
      m1 = a1; m2 = a2;
      if (mpend != 0) begin
        m1 = 0; m2 = 0; mpend = 0;
      end else if (ext_wr) begin
        if (a1 == 3) begin xb1 = 1; mpend = 1; end
        else if (a2 == 3) begin xb2 = 1; mpend = 1; end
        else begin m1 = 0; m2 = 0; end
      end else if (ext_rd) begin
        if (a1 == 3) begin xb1 = 1; m1 = 1; m2 = 2; end
        else if (a2 == 3) begin xb2 = 1; m2 = 2; m1 = (a1 != 0) ? 1 : 0; end
      end else if (pr_wr) begin
        if (a1 == 0 || a1 == 1) begin
          xf2 = (a1 == 0 && a2 == 0);
          xf1 = (a1 == 0);
          xw2 = 1; m1 = 2; m2 = 3;
        end else m1 = 3;
      end else if (pr_rd) begin
        if (a1 == 0) begin
          xf1 = 1;
          if (a2 == 0) begin xf2 = 1; m1 = 1; m2 = 2; end
          else m1 = (a2 == 3) ? 2 : 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    logic [8:0] act, exp;
    #1;
    if (rst_n && !done) begin
      act = {l1_state, l2_state, fill_l2_mem, fill_l1_l2, wr_l2, wb_l1, wb_l2};
      exp = {m1[1:0], m2[1:0], xf2, xf1, xw2, xb1, xb2};
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s: {l1,l2,f2,f1,w2,b1,b2} actual=%b expected=%b", tag, act, exp);
      end
      total++;
      if (l2_state == 2'd1 || (l1_state == 2'd3 && l2_state != 2'd3) ||
          (l1_state != 2'd0 && l2_state == 2'd0)) begin
        bad++;
        $display("FAIL R14: illegal pair actual=%0d/%0d expected legal", l1_state, l2_state);
      end
    end
  end

  task automatic drive(input logic r, input logic w, input logic xr, input logic xw,
                       input logic p1, input logic p2, input string t);
    @(negedge clk);
    pr_rd = r; pr_wr = w; ext_rd = xr; ext_wr = xw;
    l1_present = p1; l2_present = p2; tag = t;
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({l1_state, l2_state, fill_l2_mem, fill_l1_l2, wr_l2, wb_l1, wb_l2} !== 9'd0) begin
      bad++;
      $display("FAIL R1: reset outputs actual=%b expected=0",
               {l1_state, l2_state, fill_l2_mem, fill_l1_l2, wr_l2, wb_l1, wb_l2});
    end
    rst_n = 1'b1;
    drive(0,0,0,0,1,1,"R1");
    drive(0,0,0,0,1,1,"R2");
    drive(1,0,0,0,1,1,"R3");   // -> S,E with two fills
    drive(1,0,0,0,1,1,"R4");   // read hit: no change
    drive(0,1,0,0,1,1,"R5");   // S -> E, L2 M
    drive(0,1,0,0,1,1,"R6");   // E -> M
    drive(0,1,0,0,1,1,"R6");   // M stays
    drive(0,0,1,0,1,1,"R8");   // wb_l1, S/E
    drive(0,1,0,0,1,1,"R5");
    drive(0,0,1,0,1,1,"R9");   // L2 M, L1 E -> wb_l2
    drive(0,0,1,0,1,1,"R9");   // clean read: nop
    drive(0,1,1,0,1,1,"R12");  // ext read wins: no change
    drive(0,0,0,1,1,1,"R10");  // clean ext write
    drive(0,1,0,0,1,1,"R7");   // write miss both
    drive(0,1,0,0,1,1,"R6");
    drive(1,0,0,1,1,1,"R11");  // wb_l1 then invalid
    drive(1,0,0,0,1,1,"R11");  // ignored during invalidation
    drive(0,0,0,0,1,1,"R11");
    drive(1,0,0,0,1,1,"R3");
    drive(0,1,0,0,1,1,"R5");
    drive(0,0,0,0,0,1,"R13");  // L1 dropped
    drive(1,0,0,0,1,1,"R4");   // L2 M -> L1 E
    drive(0,0,0,1,0,1,"R11");  // L1 absent, L2 M -> wb_l2
    drive(0,0,0,0,1,1,"R11");
    drive(0,1,0,0,1,1,"R7");
    drive(0,0,0,0,1,0,"R13");  // L2 dropped -> both I
    drive(0,1,0,0,0,1,"R7");
    drive(0,0,1,0,0,1,"R9");   // L1 absent -> stays I
    for (int i = 0; i < 400; i++) begin
      logic [11:0] r;
      r = 12'($urandom);
      drive(r[0], r[1], r[2] & r[3], r[4] & r[5], |r[8:6], |r[11:9], "R12");
    end
    drive(0,0,0,0,1,1,"R2");
    drive(0,0,0,0,1,1,"R2");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule